// File: doc/BRIEF.md
# Correctable Error Location Capture Register

This block is a 32-bit status register. It keeps the location of the most recent correctable memory error, whether the error was in a cache or in a tightly coupled memory (TCM). Three sources send it one-cycle error-report strobes with their attributes: the instruction fetch unit (source 0), the load/store unit (source 1) and the AXI slave port (source 2). Each report passes through a qualifier that applies the update rules. The qualifier looks at whether the report is speculative or external, the error kind, the target memory, the side code and whether write-through is being forced on the data cache.

When more than one qualified report arrives in the same cycle, a fixed-priority arbiter picks one. The winner is packed into the cache layout or the TCM layout and stored on the next clock edge. A one-cycle update pulse comes out at the same time as the new value, so an event counter can count captures. Software reads and writes the register through a privileged-only access port. A non-privileged access is rejected and flagged.

Top module: `err_loc_capture`

## Requirements
- R1: Reset clears the register to zero and holds the update pulse low.
- R2: Error kind encoding: 00 parity, 01 single-bit ECC, 10 multi-bit ECC, 11 reserved. The reserved kind never updates the register. A cache report from the fetch unit (rpt_tcm=0) updates the register for parity, single-bit and multi-bit errors.
- R3: A cache report from the load/store unit updates the register for a single-bit ECC error. Parity and multi-bit errors update it only while wt_force is 1.
- R4: A TCM report (rpt_tcm=1) updates the register only for a single-bit ECC error with side 01 (first TCM) or 10 (second TCM). A cache report from the AXI slave source is ignored.
- R5: A report flagged speculative (rpt_spec) or external error/retry (rpt_ext) never updates the register.
- R6: When several qualified reports arrive in the same cycle, the load/store unit wins over the fetch unit, and both win over the AXI slave.
- R7: The cache layout places way at [29:26], 00 at [25:24], index at [13:5] and type at [1:0]. The type is 00 for the fetch unit and 01 for the load/store unit. All other bits are zero.
- R8: The TCM layout places side at [25:24], TCM address at [22:3] and type at [1:0]. The type is 00 for fetch, 01 for load/store and 10 for AXI slave. All other bits are zero.
- R9: upd_pulse is high for exactly the one cycle after a qualified report's clock edge, the same cycle in which the new value is visible.
- R10: A privileged read returns the register. A privileged write stores only the defined fields of the layout selected by wdata[25:24] (00 selects cache, any other value selects TCM), and zeroes the rest.
- R11: An access with sw_priv=0 raises sw_illegal in the same cycle and reads zero. A write in this state leaves the register unchanged.
- R12: A qualified hardware report and a privileged write in the same cycle store the hardware value.
- R13: Each qualified report overwrites the previous contents. With no report and no accepted write, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wt_force | input | 1 | Data-cache write-through is being forced |
| rpt_vld | input | 3 | Report strobe per source (0 fetch, 1 load/store, 2 AXI slave) |
| rpt_spec | input | 3 | Report is speculative |
| rpt_ext | input | 3 | Report is a TCM external error or retry |
| rpt_tcm | input | 3 | Target is TCM (1) or cache (0) |
| rpt_kind | input | 6 | Error kind, 2 bits per source |
| rpt_side | input | 6 | TCM side code, 2 bits per source |
| rpt_way | input | 12 | Cache way, 4 bits per source |
| rpt_idx | input | 27 | Cache index, 9 bits per source |
| rpt_addr | input | 60 | TCM address, 20 bits per source |
| sw_en | input | 1 | Software access strobe |
| sw_we | input | 1 | Software access is a write |
| sw_priv | input | 1 | Access is privileged |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data |
| sw_illegal | output | 1 | Non-privileged access flag |
| upd_pulse | output | 1 | One-cycle pulse on hardware capture |

## Verification
A wrong qualification or arbitration decision shows up on sw_rdata one cycle after the offending report, because the read path is combinational from the stored word. A wrong pulse shows on upd_pulse at the same edge. A packing fault puts a field in the wrong bit position or leaves a read-as-zero bit set. Each report in the bench carries a different way, index and address, so a capture that should not have happened, or a missed one, changes the value read back immediately. A mistake in the software mask or the privilege logic shows on the read one cycle after the write.

// File: rtl/err_loc_pkg.sv
package err_loc_pkg;

  localparam int NSRC    = 3;
  localparam int SRC_IFU = 0;
  localparam int SRC_LSU = 1;
  localparam int SRC_AXI = 2;

  localparam int REG_W  = 32;
  localparam int WAY_W  = 4;
  localparam int IDX_W  = 9;
  localparam int TA_W   = 20;
  localparam int KIND_W = 2;
  localparam int SIDE_W = 2;
  localparam int TYPE_W = 2;

  localparam int WAY_LSB  = 26;
  localparam int SIDE_LSB = 24;
  localparam int IDX_LSB  = 5;
  localparam int TA_LSB   = 3;
  localparam int TYPE_LSB = 0;

  typedef enum logic [KIND_W-1:0] {
    EK_PARITY = 2'b00,
    EK_SBE    = 2'b01,
    EK_MBE    = 2'b10,
    EK_RSVD   = 2'b11
  } ekind_e;

  typedef struct packed {
    logic              tcm;
    logic [KIND_W-1:0] kind;
    logic [SIDE_W-1:0] side;
    logic [WAY_W-1:0]  way;
    logic [IDX_W-1:0]  idx;
    logic [TA_W-1:0]   addr;
  } loc_t;

  // Access type code carried in the low field.
  function automatic logic [TYPE_W-1:0] src_type(input int src);
    case (src)
      SRC_IFU: return 2'b00;
      SRC_LSU: return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  // Arbitration order: rank 0 is the strongest.
  function automatic int prio_src(input int rank);
    case (rank)
      0:       return SRC_LSU;
      1:       return SRC_IFU;
      default: return SRC_AXI;
    endcase
  endfunction

  // Update rules on error kind, target and forced write-through.
  function automatic logic report_ok(input int src, input logic tcm,
                                     input logic [KIND_W-1:0] kind,
                                     input logic [SIDE_W-1:0] side,
                                     input logic wtf);
    logic ok;
    ok = 1'b0;
    if (kind != EK_RSVD) begin
      if (tcm) begin
        ok = (kind == EK_SBE) && ((side == 2'b01) || (side == 2'b10));
      end else begin
        case (src)
          SRC_IFU: ok = 1'b1;
          SRC_LSU: ok = (kind == EK_SBE) || wtf;
          default: ok = 1'b0;
        endcase
      end
    end
    return ok;
  endfunction

  function automatic logic [REG_W-1:0] pack_loc(input loc_t l,
                                                input logic [TYPE_W-1:0] typ);
    logic [REG_W-1:0] w;
    w = '0;
    if (l.tcm) begin
      w[SIDE_LSB +: SIDE_W] = l.side;
      w[TA_LSB +: TA_W]     = l.addr;
    end else begin
      w[WAY_LSB +: WAY_W]   = l.way;
      w[IDX_LSB +: IDX_W]   = l.idx;
    end
    w[TYPE_LSB +: TYPE_W] = typ;
    return w;
  endfunction

  // Defined bits of the layout chosen by the side code.
  function automatic logic [REG_W-1:0] layout_mask(input logic [SIDE_W-1:0] side);
    logic [REG_W-1:0] m;
    m = '0;
    m[SIDE_LSB +: SIDE_W] = '1;
    m[TYPE_LSB +: TYPE_W] = '1;
    if (side == 2'b00) begin
      m[WAY_LSB +: WAY_W] = '1;
      m[IDX_LSB +: IDX_W] = '1;
    end else begin
      m[TA_LSB +: TA_W]   = '1;
    end
    return m;
  endfunction

endpackage

// File: rtl/err_loc_qual.sv
module err_loc_qual
  import err_loc_pkg::*;
#(
  parameter int SRC = SRC_IFU
) (
  input  logic             vld,
  input  logic             spec,
  input  logic             ext,
  input  logic             wtf,
  input  loc_t             loc,
  output logic             hit,
  output logic [REG_W-1:0] word
);

  logic rule_ok;

  assign rule_ok = report_ok(SRC, loc.tcm, loc.kind, loc.side, wtf);
  assign hit     = vld & ~spec & ~ext & rule_ok;
  assign word    = pack_loc(loc, src_type(SRC));

endmodule

// File: rtl/err_loc_arb.sv
module err_loc_arb
  import err_loc_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]            hit,
  input  logic [N-1:0][REG_W-1:0] words,
  output logic [N-1:0]            grant,
  output logic                    any,
  output logic [REG_W-1:0]        win
);

  always_comb begin
    grant = '0;
    for (int r = N - 1; r >= 0; r--) begin
      if (hit[prio_src(r)]) begin
        grant = '0;
        grant[prio_src(r)] = 1'b1;
      end
    end
    win = '0;
    for (int s = 0; s < N; s++) begin
      if (grant[s]) win = win | words[s];
    end
  end

  assign any = |hit;

endmodule

// File: rtl/err_loc_store.sv
module err_loc_store
  import err_loc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_any,
  input  logic [REG_W-1:0] hw_word,
  input  logic             sw_en,
  input  logic             sw_we,
  input  logic             sw_priv,
  input  logic [REG_W-1:0] sw_wdata,
  output logic [REG_W-1:0] value,
  output logic             upd_pulse,
  output logic             sw_wr_ok,
  output logic             sw_illegal,
  output logic [REG_W-1:0] sw_rdata
);

  logic [REG_W-1:0] sw_masked;

  assign sw_wr_ok   = sw_en & sw_we & sw_priv;
  assign sw_illegal = sw_en & ~sw_priv;
  assign sw_masked  = sw_wdata & layout_mask(sw_wdata[SIDE_LSB +: SIDE_W]);
  assign sw_rdata   = (sw_en & sw_priv) ? value : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      value     <= '0;
      upd_pulse <= 1'b0;
    end else begin
      upd_pulse <= hw_any;
      if (hw_any) begin
        value <= hw_word;
      end else if (sw_wr_ok) begin
        value <= sw_masked;
      end
    end
  end

endmodule

// File: rtl/err_loc_capture.sv
module err_loc_capture
  import err_loc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wt_force,
  input  logic [NSRC-1:0]          rpt_vld,
  input  logic [NSRC-1:0]          rpt_spec,
  input  logic [NSRC-1:0]          rpt_ext,
  input  logic [NSRC-1:0]          rpt_tcm,
  input  logic [NSRC*KIND_W-1:0]   rpt_kind,
  input  logic [NSRC*SIDE_W-1:0]   rpt_side,
  input  logic [NSRC*WAY_W-1:0]    rpt_way,
  input  logic [NSRC*IDX_W-1:0]    rpt_idx,
  input  logic [NSRC*TA_W-1:0]     rpt_addr,
  input  logic                     sw_en,
  input  logic                     sw_we,
  input  logic                     sw_priv,
  input  logic [REG_W-1:0]         sw_wdata,
  output logic [REG_W-1:0]         sw_rdata,
  output logic                     sw_illegal,
  output logic                     upd_pulse
);

  // Named internal events, visible to the bound checker.
  logic [NSRC-1:0]            src_hit;
  logic [NSRC-1:0][REG_W-1:0] src_word;
  logic [NSRC-1:0]            grant;
  logic                       any_hit;
  logic [REG_W-1:0]           win_word;
  logic [REG_W-1:0]           value;
  logic                       sw_wr_ok;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    loc_t loc;
    assign loc.tcm  = rpt_tcm[s];
    assign loc.kind = rpt_kind[s*KIND_W +: KIND_W];
    assign loc.side = rpt_side[s*SIDE_W +: SIDE_W];
    assign loc.way  = rpt_way[s*WAY_W +: WAY_W];
    assign loc.idx  = rpt_idx[s*IDX_W +: IDX_W];
    assign loc.addr = rpt_addr[s*TA_W +: TA_W];

    err_loc_qual #(.SRC(s)) u_qual (
      .vld  (rpt_vld[s]),
      .spec (rpt_spec[s]),
      .ext  (rpt_ext[s]),
      .wtf  (wt_force),
      .loc  (loc),
      .hit  (src_hit[s]),
      .word (src_word[s])
    );
  end

  err_loc_arb #(.N(NSRC)) u_arb (
    .hit   (src_hit),
    .words (src_word),
    .grant (grant),
    .any   (any_hit),
    .win   (win_word)
  );

  err_loc_store u_store (
    .clk        (clk),
    .rst        (rst),
    .hw_any     (any_hit),
    .hw_word    (win_word),
    .sw_en      (sw_en),
    .sw_we      (sw_we),
    .sw_priv    (sw_priv),
    .sw_wdata   (sw_wdata),
    .value      (value),
    .upd_pulse  (upd_pulse),
    .sw_wr_ok   (sw_wr_ok),
    .sw_illegal (sw_illegal),
    .sw_rdata   (sw_rdata)
  );

endmodule

// File: rtl/err_loc_capture_chk.sv
module err_loc_capture_chk
  import err_loc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [NSRC-1:0]  rpt_vld,
  input logic [NSRC-1:0]  rpt_spec,
  input logic [NSRC-1:0]  rpt_ext,
  input logic [NSRC-1:0]  src_hit,
  input logic [NSRC-1:0]  grant,
  input logic             any_hit,
  input logic [REG_W-1:0] win_word,
  input logic [REG_W-1:0] value,
  input logic             sw_wr_ok,
  input logic             sw_en,
  input logic             sw_priv,
  input logic [REG_W-1:0] sw_rdata,
  input logic             sw_illegal,
  input logic             upd_pulse
);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (value == '0 && !upd_pulse));

  p_filtered_r5: assert property (@(posedge clk) disable iff (rst)
    (rpt_vld & (rpt_spec | rpt_ext) & src_hit) == '0);

  p_single_grant_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && (any_hit == (grant != '0)));

  p_axi_yields_r6: assert property (@(posedge clk) disable iff (rst)
    (src_hit[SRC_IFU] || src_hit[SRC_LSU]) |-> !grant[SRC_AXI]);

  p_lsu_first_r6: assert property (@(posedge clk) disable iff (rst)
    src_hit[SRC_LSU] |-> grant[SRC_LSU]);

  p_raz_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (value & ~layout_mask(value[SIDE_LSB +: SIDE_W])) == '0);

  p_pulse_on_r9: assert property (@(posedge clk) disable iff (rst)
    any_hit |=> upd_pulse);

  p_pulse_off_r9: assert property (@(posedge clk) disable iff (rst)
    !any_hit |=> !upd_pulse);

  p_reject_r11: assert property (@(posedge clk) disable iff (rst)
    (sw_en && !sw_priv) |-> (sw_illegal && sw_rdata == '0));

  p_hw_wins_r12: assert property (@(posedge clk) disable iff (rst)
    any_hit |=> (value == $past(win_word)));

  p_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (!any_hit && !sw_wr_ok) |=> $stable(value));

endmodule

bind err_loc_capture err_loc_capture_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .rpt_vld    (rpt_vld),
  .rpt_spec   (rpt_spec),
  .rpt_ext    (rpt_ext),
  .src_hit    (src_hit),
  .grant      (grant),
  .any_hit    (any_hit),
  .win_word   (win_word),
  .value      (value),
  .sw_wr_ok   (sw_wr_ok),
  .sw_en      (sw_en),
  .sw_priv    (sw_priv),
  .sw_rdata   (sw_rdata),
  .sw_illegal (sw_illegal),
  .upd_pulse  (upd_pulse)
);

// File: tb/err_loc_capture_tb.sv
module err_loc_capture_tb;
  import err_loc_pkg::*;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] src;
    logic       tcm;
    logic [1:0] kind;
    logic [1:0] side;
    logic       spec;
    logic       ext;
    logic       wtf;
    logic       upd;
  } vec_t;

  localparam int NV = 16;
  // src, tcm, kind, side, spec, ext, wtf, expected update
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 fetch parity
    '{2'd0, 1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 fetch multi-bit
    '{2'd1, 1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 data single-bit
    '{2'd1, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 data parity, no force
    '{2'd1, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1}, // R3 data parity, forced
    '{2'd1, 1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 data multi, no force
    '{2'd1, 1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1}, // R3 data multi, forced
    '{2'd0, 1'b1, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 TCM side 01
    '{2'd1, 1'b1, 2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 TCM side 10
    '{2'd1, 1'b1, 2'b10, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 TCM multi-bit
    '{2'd2, 1'b1, 2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 AXI TCM
    '{2'd2, 1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 AXI cache
    '{2'd0, 1'b0, 2'b01, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 speculative
    '{2'd1, 1'b1, 2'b01, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 external
    '{2'd2, 1'b1, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 bad side
    '{2'd0, 1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}  // R2 reserved kind
  };

  logic                     clk = 1'b0;
  logic                     rst;
  logic                     wt_force;
  logic [NSRC-1:0]          rpt_vld, rpt_spec, rpt_ext, rpt_tcm;
  logic [NSRC*KIND_W-1:0]   rpt_kind;
  logic [NSRC*SIDE_W-1:0]   rpt_side;
  logic [NSRC*WAY_W-1:0]    rpt_way;
  logic [NSRC*IDX_W-1:0]    rpt_idx;
  logic [NSRC*TA_W-1:0]     rpt_addr;
  logic                     sw_en, sw_we, sw_priv;
  logic [REG_W-1:0]         sw_wdata;
  logic [REG_W-1:0]         sw_rdata;
  logic                     sw_illegal;
  logic                     upd_pulse;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] shadow;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_loc_capture u_dut (
    .clk(clk), .rst(rst), .wt_force(wt_force),
    .rpt_vld(rpt_vld), .rpt_spec(rpt_spec), .rpt_ext(rpt_ext),
    .rpt_tcm(rpt_tcm), .rpt_kind(rpt_kind), .rpt_side(rpt_side),
    .rpt_way(rpt_way), .rpt_idx(rpt_idx), .rpt_addr(rpt_addr),
    .sw_en(sw_en), .sw_we(sw_we), .sw_priv(sw_priv), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .sw_illegal(sw_illegal), .upd_pulse(upd_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr_rpt();
    rpt_vld = '0; rpt_spec = '0; rpt_ext = '0; rpt_tcm = '0;
    rpt_kind = '0; rpt_side = '0; rpt_way = '0; rpt_idx = '0; rpt_addr = '0;
  endtask

  task automatic put(input int s, input logic tcm, input logic [1:0] kind,
                     input logic [1:0] side, input logic spec, input logic ext,
                     input logic [3:0] way, input logic [8:0] idx, input logic [19:0] addr);
    rpt_vld[s] = 1'b1; rpt_spec[s] = spec; rpt_ext[s] = ext; rpt_tcm[s] = tcm;
    rpt_kind[s*2 +: 2] = kind; rpt_side[s*2 +: 2] = side;
    rpt_way[s*4 +: 4] = way; rpt_idx[s*9 +: 9] = idx; rpt_addr[s*20 +: 20] = addr;
  endtask

  // Expected word restated with concatenation.
  function automatic logic [31:0] expect_word(input int s, input logic tcm,
      input logic [1:0] side, input logic [3:0] way, input logic [8:0] idx,
      input logic [19:0] addr);
    logic [1:0] t;
    t = (s == 0) ? 2'b00 : (s == 1) ? 2'b01 : 2'b10;
    if (tcm) return {6'b0, side, 1'b0, addr, 1'b0, t};
    return {2'b0, way, 2'b00, 10'b0, idx, 3'b000, t};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; wt_force = 1'b0; clr_rpt();
    sw_en = 1'b1; sw_we = 1'b0; sw_priv = 1'b1; sw_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    chk("R1 reset value", sw_rdata, 32'h0);
    chk("R1 reset pulse", {31'b0, upd_pulse}, 32'h0);

    shadow = 32'h0;
    // Table walk: R2 R3 R4 R5 R7 R8 R9 R13
    for (int i = 0; i < NV; i++) begin
      logic [3:0]  w;
      logic [8:0]  x;
      logic [19:0] a;
      w = 4'(i + 3);
      x = 9'(i * 37 + 5);
      a = 20'(i * 4099 + 11);
      @(negedge clk);
      wt_force = VEC[i].wtf;
      put(int'(VEC[i].src), VEC[i].tcm, VEC[i].kind, VEC[i].side,
          VEC[i].spec, VEC[i].ext, w, x, a);
      @(posedge clk); #1;
      if (VEC[i].upd)
        shadow = expect_word(int'(VEC[i].src), VEC[i].tcm, VEC[i].side, w, x, a);
      chk($sformatf("R13 vector %0d value", i), sw_rdata, shadow);
      chk($sformatf("R9 vector %0d pulse", i), {31'b0, upd_pulse}, {31'b0, VEC[i].upd});
      @(negedge clk); clr_rpt(); wt_force = 1'b0;
    end
    @(posedge clk); #1;
    chk("R9 pulse drops", {31'b0, upd_pulse}, 32'h0);

    // R7 packing constant
    @(negedge clk); put(1, 1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 4'h5, 9'h1A3, 20'h0);
    @(posedge clk); #1;
    chk("R7 cache layout", sw_rdata, 32'h14003461);
    @(negedge clk); clr_rpt();

    // R8 packing constant
    put(2, 1'b1, 2'b01, 2'b10, 1'b0, 1'b0, 4'hF, 9'h1FF, 20'hABCDE);
    @(posedge clk); #1;
    chk("R8 TCM layout", sw_rdata, 32'h0255E6F2);
    @(negedge clk); clr_rpt();

    // R6 three-way contention
    put(0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 4'h1, 9'h011, 20'h0);
    put(1, 1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 4'h2, 9'h022, 20'h0);
    put(2, 1'b1, 2'b01, 2'b01, 1'b0, 1'b0, 4'h0, 9'h000, 20'h12345);
    @(posedge clk); #1;
    chk("R6 load/store wins", sw_rdata, expect_word(1, 1'b0, 2'b00, 4'h2, 9'h022, 20'h0));
    @(negedge clk); clr_rpt();

    // R6 fetch against AXI
    put(0, 1'b1, 2'b01, 2'b10, 1'b0, 1'b0, 4'h0, 9'h000, 20'h00777);
    put(2, 1'b1, 2'b01, 2'b01, 1'b0, 1'b0, 4'h0, 9'h000, 20'h12345);
    @(posedge clk); #1;
    chk("R6 fetch beats AXI", sw_rdata, expect_word(0, 1'b1, 2'b10, 4'h0, 9'h000, 20'h00777));
    @(negedge clk); clr_rpt();

    // R10 write with TCM mask
    sw_we = 1'b1; sw_wdata = 32'hFFFFFFFF;
    @(posedge clk); #1;
    chk("R10 TCM mask write", sw_rdata, 32'h037FFFFB);
    @(negedge clk); sw_wdata = 32'hFCFFFFFF;
    @(posedge clk); #1;
    chk("R10 cache mask write", sw_rdata, 32'h3C003FE3);
    @(negedge clk); sw_we = 1'b0;

    // R11 non-privileged write
    sw_priv = 1'b0; sw_we = 1'b1; sw_wdata = 32'h01000008;
    #1;
    chk("R11 illegal flag", {31'b0, sw_illegal}, 32'h1);
    chk("R11 read zero", sw_rdata, 32'h0);
    @(posedge clk);
    @(negedge clk); sw_priv = 1'b1; sw_we = 1'b0;
    #1;
    chk("R11 write ignored", sw_rdata, 32'h3C003FE3);
    chk("R11 flag clears", {31'b0, sw_illegal}, 32'h0);

    // R12 hardware beats software
    @(negedge clk);
    sw_we = 1'b1; sw_wdata = 32'h00000001;
    put(0, 1'b0, 2'b01, 2'b00, 1'b0, 1'b0, 4'h9, 9'h0F0, 20'h0);
    @(posedge clk); #1;
    chk("R12 hardware wins", sw_rdata, expect_word(0, 1'b0, 2'b00, 4'h9, 9'h0F0, 20'h0));
    @(negedge clk); clr_rpt(); sw_we = 1'b0;

    // R13 back-to-back overwrite
    put(1, 1'b1, 2'b01, 2'b01, 1'b0, 1'b0, 4'h0, 9'h000, 20'h00ABC);
    @(posedge clk);
    @(negedge clk); clr_rpt();
    put(0, 1'b1, 2'b01, 2'b10, 1'b0, 1'b0, 4'h0, 9'h000, 20'h00DEF);
    @(posedge clk); #1;
    chk("R13 latest kept", sw_rdata, expect_word(0, 1'b1, 2'b10, 4'h0, 9'h000, 20'h00DEF));
    @(negedge clk); clr_rpt();

    // R1 reset mid-run
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 mid-run reset", sw_rdata, 32'h0);
    @(negedge clk) rst = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule